// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns one 32-bit instruction word into the steering and enable signals that a single-cycle datapath needs in the same cycle. It is purely combinational. The six-bit opcode in the top bits of the word picks the instruction class. For register-register instructions the six-bit function field in the bottom bits refines the choice. The block drives the write-register select, the second-operand select, the load-result select, the register-file write enable, the memory read and write strobes, the jump and branch flags, and a four-bit ALU operation code.

Two decoders work side by side. One decodes the opcode into the single-bit controls and an instruction class. The other chooses the ALU operation according to that class. Register-register instructions take it from the function field, immediate arithmetic takes it from the opcode, loads and stores take an add, and branches take a comparison. Any opcode the block does not recognise, and any unrecognised function code, leaves every write enable low and selects add. This keeps a stray word from changing architectural state.

Top module: `ctrl_decoder`

## Requirements
- R1: `reg_dst` is 1 exactly when the opcode (bits 31:26) is 0x00, which selects bits 15:11 as the destination. For every other opcode it is 0.
- R2: `alu_src` is 1 for the recognised nonzero opcodes 0x02, 0x06, 0x07, 0x08, 0x0C, 0x0D, 0x0E, 0x23 and 0x2B. It is 0 for 0x00, 0x04 and 0x05.
- R3: For the load opcode 0x23, `mem_read`, `mem_to_reg` and `reg_write` are 1, `mem_write` is 0 and `alu_op` is add (0x0). `mem_read` and `mem_to_reg` are 0 for every other opcode.
- R4: For the store opcode 0x2B, `mem_write` is 1, `reg_write` and `mem_read` are 0, and `alu_op` is add (0x0). `mem_write` is 0 for every other opcode.
- R5: `jump` is 1 only for opcode 0x02. `branch` is 1 only for opcodes 0x04 through 0x07. Both leave `reg_write` at 0.
- R6: With opcode 0x00, `alu_op` follows the function field (bits 5:0): 0x20 gives add 0x0, 0x22 gives sub 0x1, 0x24 gives and 0x2, 0x25 gives or 0x3, 0x26 gives xor 0x4, 0x27 gives nor 0x5 and 0x2A gives set-less-than 0x6. `reg_write` is 1 for each of these.
- R7: The immediate opcodes select `alu_op` from the opcode and set `reg_write`: 0x08 gives add 0x0, 0x0C gives and 0x2, 0x0D gives or 0x3 and 0x0E gives xor 0x4.
- R8: Branches select a comparison code: 0x04 gives equal 0x8, 0x05 gives not-equal 0x9, 0x06 gives less-or-equal-zero 0xA and 0x07 gives greater-than-zero 0xB. Bit 3 of `alu_op` is 1 only for these four codes.
- R9: An unrecognised opcode drives all eight single-bit outputs to 0 and `alu_op` to add (0x0).
- R10: Opcode 0x00 with an unrecognised function code keeps `reg_dst` at 1, drives every other single-bit output to 0, and sets `alu_op` to add (0x0).
- R11: Bits 25:6 never affect any output, and bits 5:0 affect outputs only when the opcode is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| reg_dst | output | 1 | 1: destination from bits 15:11, 0: from bits 20:16 |
| alu_src | output | 1 | 1: second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | 1: register write data comes from memory |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read strobe |
| mem_write | output | 1 | Data memory write strobe |
| jump | output | 1 | Next PC comes from the 26-bit jump target |
| branch | output | 1 | Next PC comes from the branch target if the condition holds |
| alu_op | output | 4 | ALU operation code |

## Verification
The assertions assume that the instruction word is fully driven with 0 and 1. They treat the outputs as settled values of that word, so they relate outputs only to one another and never to a word from an earlier cycle. The bench follows this assumption. It changes the word only on the rising clock edge, holds it stable for the whole cycle, and never drives X or Z. It covers every recognised opcode and function code, along with unrecognised values of each, while it changes the fields that must be ignored.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int ALUOP_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_RTYPE = 6'h00,
        OPC_JMP   = 6'h02,
        OPC_BEQ   = 6'h04,
        OPC_BNE   = 6'h05,
        OPC_BLEZ  = 6'h06,
        OPC_BGTZ  = 6'h07,
        OPC_ADDI  = 6'h08,
        OPC_ANDI  = 6'h0C,
        OPC_ORI   = 6'h0D,
        OPC_XORI  = 6'h0E,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B
    } opcode_e;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_XOR = 6'h26,
        FN_NOR = 6'h27,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD = 4'h0,
        ALU_SUB = 4'h1,
        ALU_AND = 4'h2,
        ALU_OR  = 4'h3,
        ALU_XOR = 4'h4,
        ALU_NOR = 4'h5,
        ALU_SLT = 4'h6,
        ALU_CEQ = 4'h8,
        ALU_CNE = 4'h9,
        ALU_CLE = 4'hA,
        ALU_CGT = 4'hB
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_REG,
        CLS_IMM,
        CLS_MEM,
        CLS_BRANCH,
        CLS_JUMP
    } icls_e;

    typedef struct packed {
        logic  reg_dst;
        logic  alu_src;
        logic  mem_to_reg;
        logic  reg_write;
        logic  mem_read;
        logic  mem_write;
        logic  jump;
        logic  branch;
        icls_e cls;
    } main_ctrl_t;

endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output main_ctrl_t       ctrl
);

    main_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = '0;
        ctrl_d.cls = CLS_NONE;
        case (opcode)
            OPC_RTYPE: begin
                ctrl_d.reg_dst   = 1'b1;
                ctrl_d.reg_write = 1'b1;
                ctrl_d.cls       = CLS_REG;
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI, OPC_XORI: begin
                ctrl_d.alu_src   = 1'b1;
                ctrl_d.reg_write = 1'b1;
                ctrl_d.cls       = CLS_IMM;
            end
            OPC_LOAD: begin
                ctrl_d.alu_src    = 1'b1;
                ctrl_d.mem_to_reg = 1'b1;
                ctrl_d.reg_write  = 1'b1;
                ctrl_d.mem_read   = 1'b1;
                ctrl_d.cls        = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl_d.alu_src   = 1'b1;
                ctrl_d.mem_write = 1'b1;
                ctrl_d.cls       = CLS_MEM;
            end
            OPC_BEQ, OPC_BNE: begin
                ctrl_d.branch = 1'b1;
                ctrl_d.cls    = CLS_BRANCH;
            end
            OPC_BLEZ, OPC_BGTZ: begin
                ctrl_d.alu_src = 1'b1;
                ctrl_d.branch  = 1'b1;
                ctrl_d.cls     = CLS_BRANCH;
            end
            OPC_JMP: begin
                ctrl_d.alu_src = 1'b1;
                ctrl_d.jump    = 1'b1;
                ctrl_d.cls     = CLS_JUMP;
            end
            default: ctrl_d.cls = CLS_NONE;
        endcase
    end

    assign ctrl = ctrl_d;

endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
    import ctrl_pkg::*;
(
    input  icls_e              cls,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FN_W-1:0]    funct,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               funct_ok
);

    alu_op_e op_d;
    logic    ok_d;

    always_comb begin
        op_d = ALU_ADD;
        ok_d = 1'b1;
        case (cls)
            CLS_REG: begin
                case (funct)
                    FN_ADD:  op_d = ALU_ADD;
                    FN_SUB:  op_d = ALU_SUB;
                    FN_AND:  op_d = ALU_AND;
                    FN_OR:   op_d = ALU_OR;
                    FN_XOR:  op_d = ALU_XOR;
                    FN_NOR:  op_d = ALU_NOR;
                    FN_SLT:  op_d = ALU_SLT;
                    default: begin
                        op_d = ALU_ADD;
                        ok_d = 1'b0;
                    end
                endcase
            end
            CLS_IMM: begin
                case (opcode)
                    OPC_ANDI: op_d = ALU_AND;
                    OPC_ORI:  op_d = ALU_OR;
                    OPC_XORI: op_d = ALU_XOR;
                    default:  op_d = ALU_ADD;
                endcase
            end
            CLS_BRANCH: begin
                case (opcode)
                    OPC_BEQ:  op_d = ALU_CEQ;
                    OPC_BNE:  op_d = ALU_CNE;
                    OPC_BLEZ: op_d = ALU_CLE;
                    default:  op_d = ALU_CGT;
                endcase
            end
            default: op_d = ALU_ADD;
        endcase
    end

    assign alu_op   = op_d;
    assign funct_ok = ok_d;

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
    import ctrl_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               reg_dst,
    output logic               alu_src,
    output logic               mem_to_reg,
    output logic               reg_write,
    output logic               mem_read,
    output logic               mem_write,
    output logic               jump,
    output logic               branch,
    output logic [ALUOP_W-1:0] alu_op
);

    localparam int OPC_LSB = INSTR_W - OPC_W;

    logic [OPC_W-1:0]   opcode;
    logic [FN_W-1:0]    funct;
    main_ctrl_t         main_ctrl;
    logic [ALUOP_W-1:0] op_sel;
    logic               funct_ok;
    logic               unused_fields;

    assign opcode        = instr[INSTR_W-1:OPC_LSB];
    assign funct         = instr[FN_W-1:0];
    assign unused_fields = ^instr[OPC_LSB-1:FN_W];

    ctrl_main_dec u_main (
        .opcode (opcode),
        .ctrl   (main_ctrl)
    );

    ctrl_alu_dec u_alu (
        .cls      (main_ctrl.cls),
        .opcode   (opcode),
        .funct    (funct),
        .alu_op   (op_sel),
        .funct_ok (funct_ok)
    );

    assign reg_dst    = main_ctrl.reg_dst;
    assign alu_src    = main_ctrl.alu_src;
    assign mem_to_reg = main_ctrl.mem_to_reg;
    assign reg_write  = main_ctrl.reg_write & funct_ok;
    assign mem_read   = main_ctrl.mem_read;
    assign mem_write  = main_ctrl.mem_write;
    assign jump       = main_ctrl.jump;
    assign branch     = main_ctrl.branch;
    assign alu_op     = op_sel;

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
    input logic       reg_dst,
    input logic       alu_src,
    input logic       mem_to_reg,
    input logic       reg_write,
    input logic       mem_read,
    input logic       mem_write,
    input logic       jump,
    input logic       branch,
    input logic [3:0] alu_op
);

    always_comb begin
        // R3: the load strobe and the load-result select always agree
        a_r3_load_pair: assert (mem_read == mem_to_reg)
            else $error("a_r3_load_pair");
        // R4: a store never writes the register file and never reads memory
        a_r4_store_quiet: assert (!mem_write || (!reg_write && !mem_read))
            else $error("a_r4_store_quiet");
        // R5: at most one of jump, branch, load or store
        a_r5_flow_excl: assert ($onehot0({jump, branch, mem_read, mem_write}))
            else $error("a_r5_flow_excl");
        // R5: control transfers never write a register
        a_r5_flow_no_wb: assert (!(jump || branch) || !reg_write)
            else $error("a_r5_flow_no_wb");
        // R1: register-register form never takes the immediate
        a_r1_dst_reg_src: assert (!reg_dst || !alu_src)
            else $error("a_r1_dst_reg_src");
        // R8: compare codes appear exactly with the branch flag
        a_r8_cmp_code: assert (branch == alu_op[3])
            else $error("a_r8_cmp_code");
        // R9: all controls low implies add
        a_r9_idle_add: assert ((reg_dst || alu_src || mem_to_reg || reg_write ||
                                mem_read || mem_write || jump || branch) ||
                               (alu_op == 4'h0))
            else $error("a_r9_idle_add");
    end

endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
    .reg_dst    (reg_dst),
    .alu_src    (alu_src),
    .mem_to_reg (mem_to_reg),
    .reg_write  (reg_write),
    .mem_read   (mem_read),
    .mem_write  (mem_write),
    .jump       (jump),
    .branch     (branch),
    .alu_op     (alu_op)
);

// File: tb/sim_ctrl_decoder.sv
`timescale 1ns/1ps
module sim_ctrl_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        reg_dst, alu_src, mem_to_reg, reg_write;
    logic        mem_read, mem_write, jump, branch;
    logic [3:0]  alu_op;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_decoder u0 (
        .instr      (instr),
        .reg_dst    (reg_dst),
        .alu_src    (alu_src),
        .mem_to_reg (mem_to_reg),
        .reg_write  (reg_write),
        .mem_read   (mem_read),
        .mem_write  (mem_write),
        .jump       (jump),
        .branch     (branch),
        .alu_op     (alu_op)
    );

    // {opcode, low six bits, expected {rd,as,m2r,rw,mr,mw,j,b,op[3:0]}}
    localparam int NV = 22;
    localparam logic [23:0] VEC [NV] = '{
        {6'h00, 6'h20, 12'b1001_0000_0000},   // R6 add
        {6'h00, 6'h22, 12'b1001_0000_0001},   // R6 sub
        {6'h00, 6'h24, 12'b1001_0000_0010},   // R6 and
        {6'h00, 6'h25, 12'b1001_0000_0011},   // R6 or
        {6'h00, 6'h26, 12'b1001_0000_0100},   // R6 xor
        {6'h00, 6'h27, 12'b1001_0000_0101},   // R6 nor
        {6'h00, 6'h2A, 12'b1001_0000_0110},   // R6 slt
        {6'h00, 6'h08, 12'b1000_0000_0000},   // R10 unknown funct
        {6'h00, 6'h3F, 12'b1000_0000_0000},   // R10 unknown funct
        {6'h02, 6'h22, 12'b0100_0010_0000},   // R5 jump
        {6'h04, 6'h27, 12'b0000_0001_1000},   // R8 eq
        {6'h05, 6'h20, 12'b0000_0001_1001},   // R8 ne
        {6'h06, 6'h24, 12'b0100_0001_1010},   // R8 lez
        {6'h07, 6'h2A, 12'b0100_0001_1011},   // R8 gtz
        {6'h08, 6'h22, 12'b0101_0000_0000},   // R7 addi
        {6'h0C, 6'h25, 12'b0101_0000_0010},   // R7 andi
        {6'h0D, 6'h24, 12'b0101_0000_0011},   // R7 ori
        {6'h0E, 6'h27, 12'b0101_0000_0100},   // R7 xori
        {6'h23, 6'h22, 12'b0111_1000_0000},   // R3 load
        {6'h2B, 6'h27, 12'b0100_0100_0000},   // R4 store
        {6'h3F, 6'h20, 12'b0000_0000_0000},   // R9 unknown opcode
        {6'h03, 6'h2A, 12'b0000_0000_0000}    // R9 unknown opcode
    };

    function automatic logic [11:0] outs();
        return {reg_dst, alu_src, mem_to_reg, reg_write,
                mem_read, mem_write, jump, branch, alu_op};
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        n_checks++;
        if (outs() !== exp) begin
            n_errors++;
            $display("FAIL %s instr=%h actual=%b expected=%b", req, instr, outs(), exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        instr <= w;
        @(negedge clk);
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R10: initial word 0x00000000 is R-type with unknown funct
        check("R10 reset word", 12'b1000_0000_0000);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] mid;
            mid = 20'(i * 32'h9E37 ^ 32'h5A5A5);
            apply({VEC[i][23:18], mid, VEC[i][17:12]});
            check($sformatf("R1/R2 vector %0d", i), VEC[i][11:0]);
        end

        // R11: middle fields all ones or all zeros leave the decode unchanged
        apply({6'h00, 20'hFFFFF, 6'h22});
        check("R11 r-type mid ones", 12'b1001_0000_0001);
        apply({6'h23, 20'h00000, 6'h2A});
        check("R11 load low bits ignored", 12'b0111_1000_0000);
        apply({6'h2B, 20'hFFFFF, 6'h3F});
        check("R4 store all-ones fields", 12'b0100_0100_0000);
        apply({6'h0E, 20'hABCDE, 6'h00});
        check("R7 xori low bits zero", 12'b0101_0000_0100);
        // R9: all-ones word is an unknown opcode
        apply(32'hFFFF_FFFF);
        check("R9 all ones", 12'b0000_0000_0000);
        // R5: jump right after a load leaves no load strobe behind
        apply({6'h23, 26'h1234567});
        apply({6'h02, 26'h1234567});
        check("R5 jump after load", 12'b0100_0010_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule